// File: doc/BRIEF.md
# Two-Endpoint Synchronous FIFO Bridge

This block sits on the device side of a host link and gives external logic a clocked, byte-wide FIFO view of two endpoint buffers. One buffer carries bytes arriving from the host, which external logic drains. The other carries bytes produced by external logic, which the host side drains. The external side picks an endpoint with a small address and moves data with active-low read, output-enable and write strobes, all sampled on the rising edge of the interface clock.

Two status flags describe the selected endpoint: one reports whether there is room to write, the other whether there is data to read. The read-data bus is first-word fall-through, so the oldest host byte is visible before any strobe is given. A plain host-side port pushes bytes into the inbound buffer under a ready signal and pops bytes from the outbound buffer. When the inbound buffer is full, the host port stalls until external logic frees space.

Top module: `sfifo_bridge`

## Requirements
- R1: While reset (active low) is held and right after it is released, both buffers are empty: at address 0 and at address 2 the room flag is high and the data flag is low, `host_rx_valid` is low and `host_tx_ready` is high.
- R2: Address 0 selects the inbound endpoint (host to device, read by external logic) and address 2 selects the outbound endpoint (device to host, written by external logic). A write strobe at any other address stores nothing, and the read and write strobes are never low together.
- R3: At address 2 the room flag is low exactly while the outbound buffer holds DEPTH bytes (512) and the data flag is low; at address 0 the data flag is high exactly while the inbound buffer holds at least one byte and the room flag is high; at addresses 1 and 3 the room flag is high and the data flag is low.
- R4: `ext_rdata` shows the oldest inbound byte with no strobe given. A byte is removed only at a rising edge where address is 0 and both `ext_rd_n` and `ext_oe_n` are low, one byte per edge.
- R5: At address 2, each rising edge with `ext_wr_n` low and room available stores one byte from `ext_wdata` into the outbound buffer.
- R6: A write attempted while the outbound buffer is full leaves the 512 stored bytes unchanged and stores nothing extra; the host reads back exactly those 512 bytes.
- R7: A read strobe while the inbound buffer is empty has no effect; later bytes still come out correctly and the data flag stays accurate.
- R8: `host_tx_ready` is low exactly while the inbound buffer holds DEPTH bytes; a host byte is accepted only at an edge with `host_tx_valid` and `host_tx_ready` high, so bytes beyond one buffer wait until space frees.
- R9: `host_rx_data` shows the oldest outbound byte while `host_rx_valid` is high; `host_rx_pop` removes it. After the host drains the outbound buffer, the room flag at address 2 returns high and the data flag stays low.
- R10: Each buffer returns bytes in the order they were stored.
- R11: Both flags reflect a buffer change in the same clock cycle the stored count changes, well within two interface clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_addr | input | 2 | Endpoint select from external logic |
| ext_rd_n | input | 1 | Active-low read strobe |
| ext_oe_n | input | 1 | Active-low output enable, must be low with the read strobe to pop |
| ext_wr_n | input | 1 | Active-low write strobe |
| ext_wdata | input | 8 | Write data from external logic |
| ext_rdata | output | 8 | Oldest inbound byte, fall-through |
| ext_room | output | 1 | Selected endpoint has room |
| ext_data | output | 1 | Selected endpoint holds data |
| host_tx_valid | input | 1 | Host offers a byte for the inbound buffer |
| host_tx_data | input | 8 | Host byte |
| host_tx_ready | output | 1 | Inbound buffer can take a byte |
| host_rx_pop | input | 1 | Host removes the oldest outbound byte |
| host_rx_data | output | 8 | Oldest outbound byte, fall-through |
| host_rx_valid | output | 1 | Outbound buffer holds data |

## Verification
A wrong pointer or count shows first on the flags, because they are decoded straight from the stored counts: a count that drifts on an empty read or a full write makes the data or room flag wrong in the very next cycle. A corrupted pointer shows at the fall-through data buses in the same cycle as the fault, since the head byte is always visible, and a lost or duplicated byte shows as an ordering mismatch at the next pop. The stimulus therefore compares every popped byte and samples flags two cycles after each burst of traffic.

// File: rtl/sfifo_bridge.sv
module sfifo_bridge #(
  parameter int DW     = 8,
  parameter int DEPTH  = 512,
  parameter int AW     = 2,
  parameter int RD_EP  = 0,
  parameter int WR_EP  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ext_addr,
  input  logic          ext_rd_n,
  input  logic          ext_oe_n,
  input  logic          ext_wr_n,
  input  logic [DW-1:0] ext_wdata,
  output logic [DW-1:0] ext_rdata,
  output logic          ext_room,
  output logic          ext_data,
  input  logic          host_tx_valid,
  input  logic [DW-1:0] host_tx_data,
  output logic          host_tx_ready,
  input  logic          host_rx_pop,
  output logic [DW-1:0] host_rx_data,
  output logic          host_rx_valid
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL   = CW'(DEPTH);
  localparam logic [PW-1:0] LAST   = PW'(DEPTH - 1);
  localparam logic [AW-1:0] A_RD   = AW'(RD_EP);
  localparam logic [AW-1:0] A_WR   = AW'(WR_EP);

  logic [DW-1:0] h2d_mem [DEPTH];
  logic [DW-1:0] d2h_mem [DEPTH];
  logic [PW-1:0] h2d_wr, h2d_rd, d2h_wr, d2h_rd;
  logic [CW-1:0] h2d_cnt, d2h_cnt;

  logic sel_rd, sel_wr;
  logic h2d_push, h2d_pop, d2h_push, d2h_pop;

  assign sel_rd   = (ext_addr == A_RD);
  assign sel_wr   = (ext_addr == A_WR);

  assign h2d_push = host_tx_valid && (h2d_cnt != FULL);
  assign h2d_pop  = sel_rd && !ext_rd_n && !ext_oe_n && (h2d_cnt != '0);
  assign d2h_push = sel_wr && !ext_wr_n && (d2h_cnt != FULL);
  assign d2h_pop  = host_rx_pop && (d2h_cnt != '0);

  always_ff @(posedge clk) begin
    if (h2d_push) h2d_mem[h2d_wr] <= host_tx_data;
    if (d2h_push) d2h_mem[d2h_wr] <= ext_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h2d_wr  <= '0;
      h2d_rd  <= '0;
      h2d_cnt <= '0;
    end else begin
      if (h2d_push) h2d_wr <= (h2d_wr == LAST) ? '0 : h2d_wr + 1'b1;
      if (h2d_pop)  h2d_rd <= (h2d_rd == LAST) ? '0 : h2d_rd + 1'b1;
      case ({h2d_push, h2d_pop})
        2'b10:   h2d_cnt <= h2d_cnt + 1'b1;
        2'b01:   h2d_cnt <= h2d_cnt - 1'b1;
        default: h2d_cnt <= h2d_cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d2h_wr  <= '0;
      d2h_rd  <= '0;
      d2h_cnt <= '0;
    end else begin
      if (d2h_push) d2h_wr <= (d2h_wr == LAST) ? '0 : d2h_wr + 1'b1;
      if (d2h_pop)  d2h_rd <= (d2h_rd == LAST) ? '0 : d2h_rd + 1'b1;
      case ({d2h_push, d2h_pop})
        2'b10:   d2h_cnt <= d2h_cnt + 1'b1;
        2'b01:   d2h_cnt <= d2h_cnt - 1'b1;
        default: d2h_cnt <= d2h_cnt;
      endcase
    end
  end

  assign ext_rdata     = h2d_mem[h2d_rd];
  assign host_rx_data  = d2h_mem[d2h_rd];
  assign host_tx_ready = (h2d_cnt != FULL);
  assign host_rx_valid = (d2h_cnt != '0);
  assign ext_room      = sel_wr ? (d2h_cnt != FULL) : 1'b1;
  assign ext_data      = sel_rd && (h2d_cnt != '0);

  AST_H2D_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    h2d_cnt <= FULL); // R8

  AST_FULL_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (d2h_cnt == FULL && !ext_wr_n && !host_rx_pop) |=> (d2h_cnt == FULL) && $stable(d2h_wr)); // R6

  AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (h2d_cnt == '0 && !host_tx_valid) |=> (h2d_cnt == '0) && $stable(h2d_rd)); // R7

  AST_ROOM_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && !ext_room && !host_rx_pop) |=> !(sel_wr && ext_room)); // R3

  AST_WRITE_GIVES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && !ext_wr_n && ext_room) |=> host_rx_valid); // R5

  AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (h2d_cnt != '0 && ext_rd_n) |=> $stable(ext_rdata)); // R4

  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_rd_n && !ext_wr_n)); // R2

endmodule

// File: tb/tb_sfifo_bridge.sv
`timescale 1ns/1ps
module tb_sfifo_bridge;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ext_addr = 2'd0;
  logic       ext_rd_n = 1'b1, ext_oe_n = 1'b1, ext_wr_n = 1'b1;
  logic [7:0] ext_wdata = '0;
  logic [7:0] ext_rdata;
  logic       ext_room, ext_data;
  logic       host_tx_valid = 1'b0;
  logic [7:0] host_tx_data = '0;
  logic       host_tx_ready;
  logic       host_rx_pop = 1'b0;
  logic [7:0] host_rx_data;
  logic       host_rx_valid;

  always #2.5 clk = ~clk;

  sfifo_bridge dut (
    .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .ext_rd_n(ext_rd_n),
    .ext_oe_n(ext_oe_n), .ext_wr_n(ext_wr_n), .ext_wdata(ext_wdata),
    .ext_rdata(ext_rdata), .ext_room(ext_room), .ext_data(ext_data),
    .host_tx_valid(host_tx_valid), .host_tx_data(host_tx_data),
    .host_tx_ready(host_tx_ready), .host_rx_pop(host_rx_pop),
    .host_rx_data(host_rx_data), .host_rx_valid(host_rx_valid));

  int checks = 0;
  int errors = 0;
  int seq = 0;
  logic [7:0] q[$];
  logic [7:0] dq[$];

  // {push count, pop count, forced pop, expected data flag}
  localparam int NV = 8;
  localparam logic [31:0] VEC [NV] = '{
    {12'd1,   12'd1,   4'd0, 4'd0},
    {12'd33,  12'd33,  4'd0, 4'd0},
    {12'd0,   12'd1,   4'd1, 4'd0},
    {12'd1,   12'd1,   4'd0, 4'd0},
    {12'd512, 12'd0,   4'd0, 4'd1},
    {12'd0,   12'd512, 4'd0, 4'd0},
    {12'd517, 12'd512, 4'd0, 4'd1},
    {12'd0,   12'd5,   4'd0, 4'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] next_byte();
    seq++;
    return 8'(seq * 37 + 11);
  endfunction

  task automatic push_n(input int n);
    int left = n;
    while (left > 0) begin
      @(negedge clk);
      if (host_tx_ready) begin
        host_tx_valid = 1'b1;
        host_tx_data  = next_byte();
        q.push_back(host_tx_data);
        left--;
      end else begin
        host_tx_valid = 1'b0;
      end
    end
    @(negedge clk);
    host_tx_valid = 1'b0;
  endtask

  task automatic pop_n(input int n, input bit force_it);
    int left = n;
    int guard = 0;
    while (left > 0 && guard < 5000) begin
      @(negedge clk);
      guard++;
      if (force_it || ext_data) begin
        if (!force_it) begin
          chk(ext_rdata == q[0], "R10 inbound order", ext_rdata, q[0]);
          void'(q.pop_front());
        end
        ext_rd_n = 1'b0;
        ext_oe_n = 1'b0;
        left--;
      end else begin
        ext_rd_n = 1'b1;
        ext_oe_n = 1'b1;
      end
    end
    @(negedge clk);
    ext_rd_n = 1'b1;
    ext_oe_n = 1'b1;
    if (guard >= 5000) chk(1'b0, "R4 pop stalled", left, 0);
  endtask

  task automatic ext_write_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ext_wr_n  = 1'b0;
      ext_wdata = next_byte();
      dq.push_back(ext_wdata);
    end
    @(negedge clk);
    ext_wr_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (13) @(negedge clk);
    chk(ext_room == 1'b1 && ext_data == 1'b0, "R1 flags in reset", {ext_room, ext_data}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ext_room == 1'b1 && ext_data == 1'b0, "R1 addr0 flags", {ext_room, ext_data}, 2'b10);
    ext_addr = 2'd2;
    @(negedge clk);
    chk(ext_room == 1'b1 && ext_data == 1'b0, "R1 addr2 flags", {ext_room, ext_data}, 2'b10);
    chk(!host_rx_valid && host_tx_ready, "R1 host side idle", {host_rx_valid, host_tx_ready}, 2'b01);
    ext_addr = 2'd0;

    for (int v = 0; v < NV; v++) begin
      fork
        push_n(int'(VEC[v][31:20]));
        pop_n(int'(VEC[v][19:8]), VEC[v][4]);
      join
      repeat (2) @(negedge clk);
      chk(ext_data == VEC[v][0], "R3 data flag after vector", ext_data, VEC[v][0]);
      chk(host_tx_ready == (q.size() < 512), "R8 host ready", host_tx_ready, q.size() < 512);
      chk(ext_data == (q.size() != 0), "R11 flag tracks count", ext_data, q.size() != 0);
    end
    chk(q.size() == 0, "R7 no phantom bytes", q.size(), 0);

    push_n(1);
    ext_addr = 2'd1;
    @(negedge clk);
    chk(ext_data == 1'b0 && ext_room == 1'b1, "R3 unused address flags", {ext_room, ext_data}, 2'b10);
    ext_addr = 2'd0;
    ext_rd_n = 1'b0;
    ext_oe_n = 1'b1;
    repeat (2) @(negedge clk);
    ext_rd_n = 1'b1;
    chk(ext_data == 1'b1 && ext_rdata == q[0], "R4 pop needs output enable", ext_rdata, q[0]);
    pop_n(1, 1'b0);
    @(negedge clk);
    chk(ext_data == 1'b0, "R4 single pop per edge", ext_data, 0);

    ext_addr = 2'd0;
    ext_wr_n = 1'b0;
    repeat (3) @(negedge clk);
    ext_wr_n = 1'b1;
    @(negedge clk);
    chk(host_rx_valid == 1'b0, "R2 write at address 0 ignored", host_rx_valid, 0);

    ext_addr = 2'd2;
    ext_write_n(511);
    chk(ext_room == 1'b1 && host_rx_valid, "R5 room before last byte", ext_room, 1);
    ext_write_n(1);
    chk(ext_room == 1'b0, "R3 room low when full", ext_room, 0);
    chk(ext_data == 1'b0, "R3 data flag low at address 2", ext_data, 0);

    @(negedge clk);
    ext_wr_n  = 1'b0;
    ext_wdata = 8'hCE;
    repeat (3) @(negedge clk);
    ext_wr_n = 1'b1;
    @(negedge clk);
    chk(ext_room == 1'b0, "R6 full write keeps full", ext_room, 0);

    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      chk(host_rx_valid && host_rx_data == dq[i], "R6 outbound order", host_rx_data, dq[i]);
      host_rx_pop = 1'b1;
    end
    @(negedge clk);
    host_rx_pop = 1'b0;
    chk(host_rx_valid == 1'b0, "R6 no extra byte stored", host_rx_valid, 0);
    chk(ext_room == 1'b1, "R9 room back after drain", ext_room, 1);
    chk(ext_data == 1'b0, "R9 data flag low after drain", ext_data, 0);

    finish_run();
  end
endmodule